// File: doc/BRIEF.md
# Receive Link-Rate Reconfiguration Controller

This controller sits between a sink-side link core and a transceiver reconfiguration port. It takes the receiver through its power-up reset sequence. After that it serves requests for a new receive bit rate. The three rates all run from one shared 135 MHz reference clock. A rate is changed only by rewriting the divider ratio of the receive clock-recovery PLL; the reference clock is never switched. The link core raises `link_req` with a 2-bit rate code. The controller answers with a one-cycle acknowledge. It then issues one divider-write command to the reconfiguration port and holds `link_busy` high until that port reports completion.

A programmable limit bounds the wait for completion. If no `rcfg_done` pulse arrives within `wait_limit` cycles, the controller releases busy anyway and raises a sticky error flag. The receiver digital reset covers the whole reconfiguration and is released one cycle after busy falls.

The state machine has seven states: PWRUP (power-up reset sequence running), IDLE (waiting for a request), ACK (acknowledge pulse), WRITE (divider-write command), WAIT (waiting for done or timeout), RELEASE (busy low, digital reset still held) and DRAIN (waiting for the request line to fall). The transitions are:
- PWRUP→IDLE when the reset sequence ends.
- IDLE→ACK on a request with a valid code.
- ACK→WRITE and WRITE→WAIT unconditionally.
- WAIT→RELEASE on done or on timeout.
- RELEASE→DRAIN unconditionally.
- DRAIN→IDLE once `link_req` is low.

Top module: `rate_reconfig_ctrl`

## Requirements
- R1: After reset is released, `rx_ana_rst` stays high for ANA_CYC cycles and `rx_dig_rst` for ANA_CYC+DIG_CYC cycles. No request is acknowledged before the state machine has passed from PWRUP to IDLE, which happens one cycle after the sequence ends.
- R2: A request seen in IDLE with a valid code produces `link_ack` high for exactly one cycle, in the cycle after the request is sampled. `link_busy` is low during that cycle.
- R3: Rate code 2'b11 is ignored: there is no acknowledge, no write, and `rcfg_div` keeps its previous value.
- R4: In the cycle after the acknowledge, `rcfg_wr` is high for exactly one cycle with `link_busy` high. Each accepted request produces exactly one write.
- R5: `rcfg_div` carries DIV_RBR for code 2'b00, DIV_HBR for 2'b01 and DIV_HBR2 for 2'b10. Its reset value is DIV_RBR, and it is stable while busy is high.
- R6: `link_busy` goes high with the write cycle. If `rcfg_done` is high d cycles after the write cycle (1 ≤ d ≤ limit), busy is high for exactly d+1 cycles and then falls.
- R7: If no done arrives within `limit` wait cycles, busy is high for limit+1 cycles and `rcfg_err` rises in the cycle busy falls. Here limit is `wait_limit`, with 0 treated as 1. The error stays set until the next acknowledge clears it.
- R8: `rx_dig_rst` is high while busy is high and in the first cycle after busy falls, and low from the cycle after that.
- R9: A new request is accepted only after the request line has gone low. Holding `link_req` high after completion gives no further acknowledge.
- R10: `rcfg_done` outside the wait phase has no effect on busy, the error flag or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_req | input | 1 | Rate-change request from the link core |
| link_rate | input | 2 | Requested rate code (00, 01, 10; 11 ignored) |
| link_ack | output | 1 | One-cycle acknowledge of a request |
| link_busy | output | 1 | High while reconfiguration is in progress |
| rcfg_wr | output | 1 | One-cycle divider-write command |
| rcfg_div | output | DIV_W | Divider ratio for the selected rate |
| rcfg_done | input | 1 | Completion pulse from the reconfiguration port |
| wait_limit | input | TO_W | Maximum wait cycles for completion |
| rx_ana_rst | output | 1 | Receiver analog reset |
| rx_dig_rst | output | 1 | Receiver digital reset |
| rcfg_err | output | 1 | Sticky completion-timeout flag |

## Verification
The bench builds the block with ANA_CYC=4, DIG_CYC=3 and TO_W=4, with the default divider values. The short power-up sequence allows a cycle-by-cycle comparison of both reset outputs against their computed lengths, with a request raised and dropped inside it. The small limit allows a full sweep: wait limits 0, 1 and 3 are combined with every done delay from 1 to two beyond the limit and with all three valid codes. This covers the done-wins-on-the-last-cycle boundary, the timeout case and late done pulses that must be ignored. The invalid code is exercised separately.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_ACK,
        ST_WRITE,
        ST_WAIT,
        ST_RELEASE,
        ST_DRAIN
    } rc_state_t;

    localparam logic [1:0] RATE_LOW  = 2'b00;
    localparam logic [1:0] RATE_MID  = 2'b01;
    localparam logic [1:0] RATE_HIGH = 2'b10;
    localparam logic [1:0] RATE_BAD  = 2'b11;

endpackage

// File: rtl/rc_pwr_seq.sv
module rc_pwr_seq #(
    parameter int ANA_CYC = 16,
    parameter int DIG_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic ana_rst,
    output logic dig_rst,
    output logic ready
);
    localparam int TOTAL = ANA_CYC + DIG_CYC;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] ANA_END = CW'(ANA_CYC);
    localparam logic [CW-1:0] ALL_END = CW'(TOTAL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != ALL_END) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Analog reset covers the first phase, digital reset both phases.
    assign ana_rst = (cnt < ANA_END);
    assign dig_rst = (cnt < ALL_END);
    assign ready   = (cnt == ALL_END);
endmodule

// File: rtl/rc_div_sel.sv
module rc_div_sel
    import rc_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int DIV_RBR  = 12,
    parameter int DIV_HBR  = 20,
    parameter int DIV_HBR2 = 40
) (
    input  logic [1:0]       code,
    output logic [DIV_W-1:0] div,
    output logic             valid
);
    always_comb begin
        valid = 1'b1;
        unique case (code)
            RATE_LOW:  div = DIV_W'(DIV_RBR);
            RATE_MID:  div = DIV_W'(DIV_HBR);
            RATE_HIGH: div = DIV_W'(DIV_HBR2);
            RATE_BAD: begin
                div   = DIV_W'(DIV_RBR);
                valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rc_wait_timer.sv
module rc_wait_timer #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expired during the limit-th wait cycle; a limit of 0 acts as 1.
    assign expired = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});
endmodule

// File: rtl/rate_reconfig_ctrl.sv
module rate_reconfig_ctrl
    import rc_pkg::*;
#(
    parameter int ANA_CYC  = 16,
    parameter int DIG_CYC  = 16,
    parameter int DIV_W    = 8,
    parameter int TO_W     = 8,
    parameter int DIV_RBR  = 12,
    parameter int DIV_HBR  = 20,
    parameter int DIV_HBR2 = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_req,
    input  logic [1:0]       link_rate,
    output logic             link_ack,
    output logic             link_busy,
    output logic             rcfg_wr,
    output logic [DIV_W-1:0] rcfg_div,
    input  logic             rcfg_done,
    input  logic [TO_W-1:0]  wait_limit,
    output logic             rx_ana_rst,
    output logic             rx_dig_rst,
    output logic             rcfg_err
);
    rc_state_t state, state_nx;

    logic             seq_ana, seq_dig, seq_ready;
    logic [DIV_W-1:0] sel_div;
    logic             sel_valid;
    logic             tmr_expired;
    logic             hold_dig;
    logic             accept;

    rc_pwr_seq #(
        .ANA_CYC (ANA_CYC),
        .DIG_CYC (DIG_CYC)
    ) pwr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ana_rst (seq_ana),
        .dig_rst (seq_dig),
        .ready   (seq_ready)
    );

    rc_div_sel #(
        .DIV_W    (DIV_W),
        .DIV_RBR  (DIV_RBR),
        .DIV_HBR  (DIV_HBR),
        .DIV_HBR2 (DIV_HBR2)
    ) sel_i (
        .code  (link_rate),
        .div   (sel_div),
        .valid (sel_valid)
    );

    rc_wait_timer #(
        .TO_W (TO_W)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_WAIT),
        .limit   (wait_limit),
        .expired (tmr_expired)
    );

    assign accept = (state == ST_IDLE) && link_req && sel_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PWRUP;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PWRUP:   if (seq_ready) state_nx = ST_IDLE;
            ST_IDLE:    if (accept) state_nx = ST_ACK;
            ST_ACK:     state_nx = ST_WRITE;
            ST_WRITE:   state_nx = ST_WAIT;
            ST_WAIT:    if (rcfg_done || tmr_expired) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = ST_DRAIN;
            ST_DRAIN:   if (!link_req) state_nx = ST_IDLE;
            default:    state_nx = ST_PWRUP;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        link_ack  = 1'b0;
        link_busy = 1'b0;
        rcfg_wr   = 1'b0;
        hold_dig  = 1'b0;
        unique case (state)
            ST_ACK:     link_ack = 1'b1;
            ST_WRITE: begin
                link_busy = 1'b1;
                rcfg_wr   = 1'b1;
                hold_dig  = 1'b1;
            end
            ST_WAIT: begin
                link_busy = 1'b1;
                hold_dig  = 1'b1;
            end
            ST_RELEASE: hold_dig = 1'b1;
            default: ;
        endcase
    end

    // Divider and error registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcfg_div <= DIV_W'(DIV_RBR);
            rcfg_err <= 1'b0;
        end else begin
            if (accept) begin
                rcfg_div <= sel_div;
                rcfg_err <= 1'b0;
            end else if (state == ST_WAIT && !rcfg_done && tmr_expired) begin
                rcfg_err <= 1'b1;
            end
        end
    end

    assign rx_ana_rst = seq_ana;
    assign rx_dig_rst = seq_dig | hold_dig;
endmodule

// File: rtl/rate_reconfig_ctrl_chk.sv
module rate_reconfig_ctrl_chk #(
    parameter int DIV_W = 8,
    parameter int TO_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             link_req,
    input logic [1:0]       link_rate,
    input logic             link_ack,
    input logic             link_busy,
    input logic             rcfg_wr,
    input logic [DIV_W-1:0] rcfg_div,
    input logic             rcfg_done,
    input logic [TO_W-1:0]  wait_limit,
    input logic             rx_ana_rst,
    input logic             rx_dig_rst,
    input logic             rcfg_err
);
    p_no_ack_in_pwrup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ana_rst |-> !link_ack);

    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        link_ack |=> !link_ack);

    p_ack_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        link_ack |-> !link_busy);

    p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_req && link_rate == 2'b11 && !link_ack && !link_busy && !rcfg_wr)
            |=> !link_ack);

    p_wr_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        link_ack |=> (rcfg_wr && link_busy));

    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rcfg_wr |=> !rcfg_wr);

    p_div_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        link_busy |-> $stable(rcfg_div));

    p_err_with_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rcfg_err) |-> (!link_busy && $past(link_busy)));

    p_dig_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        link_busy |-> rx_dig_rst);

    p_dig_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_busy) |=> !rx_dig_rst);
endmodule

bind rate_reconfig_ctrl rate_reconfig_ctrl_chk #(.DIV_W(DIV_W), .TO_W(TO_W)) chk_i (.*);

// File: tb/rate_reconfig_ctrl_tb_top.sv
module rate_reconfig_ctrl_tb_top;
    localparam int ANA = 4;
    localparam int DIG = 3;
    localparam int DW  = 8;
    localparam int TW  = 4;
    localparam int D0  = 12;
    localparam int D1  = 20;
    localparam int D2  = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_req = 1'b0;
    logic [1:0]    link_rate = 2'b00;
    logic          link_ack, link_busy, rcfg_wr;
    logic [DW-1:0] rcfg_div;
    logic          rcfg_done = 1'b0;
    logic [TW-1:0] wait_limit = '0;
    logic          rx_ana_rst, rx_dig_rst, rcfg_err;

    int n_checks = 0;
    int n_errors = 0;
    int cur_div  = D0;

    always #4 clk = ~clk;

    rate_reconfig_ctrl #(
        .ANA_CYC (ANA), .DIG_CYC (DIG), .DIV_W (DW), .TO_W (TW),
        .DIV_RBR (D0), .DIV_HBR (D1), .DIV_HBR2 (D2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .link_req (link_req), .link_rate (link_rate),
        .link_ack (link_ack), .link_busy (link_busy), .rcfg_wr (rcfg_wr),
        .rcfg_div (rcfg_div), .rcfg_done (rcfg_done), .wait_limit (wait_limit),
        .rx_ana_rst (rx_ana_rst), .rx_dig_rst (rx_dig_rst), .rcfg_err (rcfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int div_of(input int code);
        return (code == 0) ? D0 : (code == 1) ? D1 : D2;
    endfunction

    // One accepted request; done comes d cycles after the write cycle.
    task automatic run_req(input int code, input int d, input int lim);
        int teff;
        int exp_busy;
        bit exp_err;
        teff     = (lim == 0) ? 1 : lim;
        exp_busy = ((d < teff) ? d : teff) + 1;
        exp_err  = (d > teff);
        wait_limit = TW'(lim);
        link_rate  = 2'(code);
        link_req   = 1'b1;
        tick();
        chk(link_ack == 1'b1, "R2 ack", int'(link_ack), 1);
        chk(link_busy == 1'b0, "R2 busy during ack", int'(link_busy), 0);
        chk(rcfg_err == 1'b0, "R7 err cleared at ack", int'(rcfg_err), 0);
        tick();
        chk(link_ack == 1'b0, "R2 ack width", int'(link_ack), 0);
        chk(rcfg_wr == 1'b1, "R4 write", int'(rcfg_wr), 1);
        chk(link_busy == 1'b1, "R6 busy at write", int'(link_busy), 1);
        chk(int'(rcfg_div) == div_of(code), "R5 divider", int'(rcfg_div), div_of(code));
        cur_div = div_of(code);
        fork
            begin
                repeat (d) @(posedge clk);
                #2 rcfg_done = 1'b1;
                @(posedge clk);
                #2 rcfg_done = 1'b0;
            end
            begin
                int nb;
                nb = 1;
                forever begin
                    tick();
                    if (!link_busy) break;
                    nb++;
                    chk(rx_dig_rst == 1'b1, "R8 dig reset while busy", int'(rx_dig_rst), 1);
                    chk(rcfg_wr == 1'b0, "R4 single write", int'(rcfg_wr), 0);
                end
                chk(nb == exp_busy, exp_err ? "R7 busy length on timeout" : "R6 busy length",
                    nb, exp_busy);
                chk(rcfg_err == exp_err, "R7 error flag", int'(rcfg_err), int'(exp_err));
                chk(rx_dig_rst == 1'b1, "R8 dig reset one cycle after busy", int'(rx_dig_rst), 1);
                tick();
                chk(rx_dig_rst == 1'b0, "R8 dig reset released", int'(rx_dig_rst), 0);
            end
        join
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(link_ack == 1'b0, "R9 no ack while req held", int'(link_ack), 0);
            chk(link_busy == 1'b0, "R10 late done has no effect", int'(link_busy), 0);
            chk(rcfg_err == exp_err, "R10 error unchanged by late done", int'(rcfg_err), int'(exp_err));
        end
        link_req = 1'b0;
        tick();
        tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : stim
        int lims[3];
        int code;
        lims[0] = 0;
        lims[1] = 1;
        lims[2] = 3;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(rx_ana_rst == 1'b1, "R1 analog reset at release", int'(rx_ana_rst), 1);
        chk(rx_dig_rst == 1'b1, "R1 digital reset at release", int'(rx_dig_rst), 1);
        chk(int'(rcfg_div) == D0, "R5 reset divider", int'(rcfg_div), D0);
        chk(link_busy == 1'b0 && rcfg_err == 1'b0 && link_ack == 1'b0,
            "R2 reset outputs idle", int'({link_busy, rcfg_err, link_ack}), 0);
        for (int k = 1; k <= 12; k++) begin
            tick();
            if (k == 2) begin
                link_rate = 2'b01;
                link_req  = 1'b1;
            end
            if (k == 6) link_req = 1'b0;
            chk(rx_ana_rst == (k < ANA), "R1 analog reset length", int'(rx_ana_rst), int'(k < ANA));
            chk(rx_dig_rst == (k < ANA + DIG), "R1 digital reset length",
                int'(rx_dig_rst), int'(k < ANA + DIG));
            chk(link_ack == 1'b0, "R1 no ack during power-up", int'(link_ack), 0);
        end

        code = 0;
        for (int li = 0; li < 3; li++) begin
            int teff;
            teff = (lims[li] == 0) ? 1 : lims[li];
            for (int d = 1; d <= teff + 2; d++) begin
                run_req(code, d, lims[li]);
                code = (code + 1) % 3;
            end
        end

        // Invalid code is ignored
        link_rate = 2'b11;
        link_req  = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(link_ack == 1'b0, "R3 no ack for code 11", int'(link_ack), 0);
            chk(rcfg_wr == 1'b0, "R3 no write for code 11", int'(rcfg_wr), 0);
            chk(int'(rcfg_div) == cur_div, "R3 divider kept", int'(rcfg_div), cur_div);
        end
        link_req = 1'b0;
        tick();
        run_req(2, 2, 5);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule